// File: doc/BRIEF.md
# Uncorrectable-Error Read Retry Controller

This block sits on the return path between a memory read channel and its requester. It accepts one read request at a time, issues the read command, and inspects the ECC status that comes back with the read data. When the status marks the data uncorrectable and retry is enabled, it issues the same read again instead of handing the bad data upward. This repeats until a clean or correctable result arrives or the programmed retry budget runs out.

A read that recovers is forwarded normally, and a corrected-error log strobe is raised. A correctable result on the first attempt also raises that strobe. A read that never recovers is forwarded with its poison bit set, and a deferred-error log strobe is raised. It does not signal a fatal error. Each log strobe carries the request address and the number of read attempts used. ECC decoding is done upstream; this block only reads the 2-bit status.

Top module: `rd_retry_ctl`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1 and `cmd_valid`, `fwd_valid`, `log_ce` and `log_de` are 0.
- R2: While idle, a request with `req_valid` high is accepted in that cycle, and `cmd_valid` is high in that same cycle with `cmd_addr` equal to `req_addr`. `req_ready` is 0 from the next cycle until the read is forwarded.
- R3: The ECC status is coded as follows: 2'b00 is clean, 2'b01 is correctable, and 2'b10 or 2'b11 is uncorrectable. An uncorrectable response with retry budget left makes `cmd_valid` high in the cycle after the response, with the address of the original request.
- R4: A read is forwarded (`fwd_valid` high for one cycle, carrying the data of the final response) in the cycle after its final response. A clean first attempt is forwarded with `fwd_poison` 0 and no log strobe.
- R5: A correctable first attempt is forwarded unpoisoned with `log_ce` high, `log_tries` 1 and `log_addr` equal to the request address.
- R6: A clean or correctable response after one or more retries is forwarded unpoisoned with `log_ce` high and `log_tries` equal to the number of read commands issued.
- R7: With retry enabled and a budget of N (the 3-bit `cfg_max_retry`, 1 to 7), a read that stays uncorrectable is issued N+1 times in total. It is then forwarded with `fwd_poison` 1, `log_de` high and `log_tries` equal to N+1.
- R8: When `cfg_retry_en` is 0, or the budget is 0, an uncorrectable first response is poisoned at once with `log_de` high and `log_tries` 1, and no retry command is issued.
- R9: `cfg_retry_en` and `cfg_max_retry` are sampled when a request is accepted. Changing them during the sequence has no effect on it.
- R10: A response that arrives while no read is pending is ignored: no forward, no log strobe and no command.
- R11: `req_ready` returns to 1 in the cycle after the forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_retry_en | input | 1 | Retry enable, sampled at accept |
| cfg_max_retry | input | MAX_W (3) | Retry budget, sampled at accept |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW (32) | Read address |
| cmd_valid | output | 1 | Read command to memory |
| cmd_addr | output | AW | Read command address |
| rsp_valid | input | 1 | Read response present |
| rsp_data | input | DW (64) | Read response data |
| rsp_ecc | input | 2 | ECC status of the response |
| fwd_valid | output | 1 | Forwarded response strobe |
| fwd_data | output | DW | Forwarded data |
| fwd_poison | output | 1 | Forwarded data is poisoned |
| log_ce | output | 1 | Corrected-error log strobe |
| log_de | output | 1 | Deferred-error log strobe |
| log_addr | output | AW | Address of the logged read |
| log_tries | output | MAX_W+1 (4) | Read attempts used |

## Verification
If the retry counter is wrong, the visible effect is an extra or a missing `cmd_valid` pulse one cycle after an uncorrectable response. The forward then moves by a whole response latency, and `log_tries` is wrong. The bench compares command, ready, forward and log outputs on every cycle, so such a fault shows at the first misplaced command. If the configuration is captured at the wrong time, a sequence where the settings change mid-flight ends with the wrong attempt count. If a stray response reaches the state machine, a forward appears while the block is idle.

// File: rtl/rd_retry_pkg.sv
`timescale 1ns/1ps
package rd_retry_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT_RESP,
      ST_RETRY_ISSUE,
      ST_DONE
   } rr_state_e;

   localparam logic [1:0] ECC_CLEAN = 2'b00;
   localparam logic [1:0] ECC_CORR  = 2'b01;

   function automatic logic ecc_is_uncorr(input logic [1:0] st);
      return st[1];
   endfunction
endpackage

// File: rtl/rd_retry_fsm.sv
`timescale 1ns/1ps
module rd_retry_fsm
   import rd_retry_pkg::*;
#(
   parameter int AW    = 32,
   parameter int MAX_W = 3,
   localparam int TRY_W = MAX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_retry_en,
   input  logic [MAX_W-1:0] cfg_max_retry,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [AW-1:0]    req_addr,
   output logic             cmd_valid,
   output logic [AW-1:0]    cmd_addr,
   input  logic             rsp_valid,
   input  logic [1:0]       rsp_ecc,
   output logic             fin,
   output logic             fin_poison,
   output logic             fin_ce,
   output logic [AW-1:0]    fin_addr,
   output logic [TRY_W-1:0] fin_tries
);
   rr_state_e        state_q, state_d;
   logic [AW-1:0]    addr_q;
   logic [MAX_W-1:0] lim_q;
   logic [MAX_W-1:0] tries_q;
   logic             accept, take_rsp, rsp_ue, do_retry;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign take_rsp  = (state_q == ST_WAIT_RESP) && rsp_valid;
   assign rsp_ue    = ecc_is_uncorr(rsp_ecc);
   assign do_retry  = take_rsp && rsp_ue && (tries_q < lim_q);

   assign cmd_valid = accept || (state_q == ST_RETRY_ISSUE);
   assign cmd_addr  = accept ? req_addr : addr_q;

   assign fin        = take_rsp && !do_retry;
   assign fin_poison = rsp_ue;
   assign fin_ce     = !rsp_ue && ((tries_q != '0) || (rsp_ecc == ECC_CORR));
   assign fin_addr   = addr_q;
   assign fin_tries  = TRY_W'(tries_q) + TRY_W'(1);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:        if (accept) state_d = ST_WAIT_RESP;
         ST_WAIT_RESP: begin
            if (do_retry)      state_d = ST_RETRY_ISSUE;
            else if (take_rsp) state_d = ST_DONE;
         end
         ST_RETRY_ISSUE: state_d = ST_WAIT_RESP;
         ST_DONE:        state_d = ST_IDLE;
         default:        state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         lim_q   <= '0;
         tries_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q  <= req_addr;
            lim_q   <= cfg_retry_en ? cfg_max_retry : '0;
            tries_q <= '0;
         end else if (do_retry) begin
            tries_q <= tries_q + MAX_W'(1);
         end
      end
   end

   // R3: a retry command only ever follows an accepted response
   a_r3_reissue_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RETRY_ISSUE) |-> $past(rsp_valid));
   // R7: retries never exceed the budget captured at accept
   a_r7_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q <= lim_q);
   // R2: no new request is taken while a sequence is busy
   a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
endmodule

// File: rtl/rd_retry_out.sv
`timescale 1ns/1ps
module rd_retry_out #(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int TRY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fin,
   input  logic             fin_poison,
   input  logic             fin_ce,
   input  logic [AW-1:0]    fin_addr,
   input  logic [TRY_W-1:0] fin_tries,
   input  logic [DW-1:0]    rsp_data,
   output logic             fwd_valid,
   output logic [DW-1:0]    fwd_data,
   output logic             fwd_poison,
   output logic             log_ce,
   output logic             log_de,
   output logic [AW-1:0]    log_addr,
   output logic [TRY_W-1:0] log_tries
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid  <= 1'b0;
         fwd_data   <= '0;
         fwd_poison <= 1'b0;
         log_ce     <= 1'b0;
         log_de     <= 1'b0;
         log_addr   <= '0;
         log_tries  <= '0;
      end else begin
         fwd_valid <= fin;
         log_ce    <= fin && fin_ce;
         log_de    <= fin && fin_poison;
         if (fin) begin
            fwd_data   <= rsp_data;
            fwd_poison <= fin_poison;
            log_addr   <= fin_addr;
            log_tries  <= fin_tries;
         end
      end
   end

   // R4: each forward is a single-cycle strobe
   a_r4_fwd_single: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |=> !fwd_valid);
   // R5: log strobes only accompany a forward and never both at once
   a_r5_log_with_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (log_ce || log_de) |-> (fwd_valid && !(log_ce && log_de)));
   // R7: poison and deferred log go together
   a_r7_poison_is_de: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (fwd_poison == log_de));
endmodule

// File: rtl/rd_retry_ctl.sv
`timescale 1ns/1ps
module rd_retry_ctl #(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int MAX_W = 3,
   localparam int TRY_W = MAX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_retry_en,
   input  logic [MAX_W-1:0] cfg_max_retry,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [AW-1:0]    req_addr,
   output logic             cmd_valid,
   output logic [AW-1:0]    cmd_addr,
   input  logic             rsp_valid,
   input  logic [DW-1:0]    rsp_data,
   input  logic [1:0]       rsp_ecc,
   output logic             fwd_valid,
   output logic [DW-1:0]    fwd_data,
   output logic             fwd_poison,
   output logic             log_ce,
   output logic             log_de,
   output logic [AW-1:0]    log_addr,
   output logic [TRY_W-1:0] log_tries
);
   if (AW < 1) begin : g_bad_aw
      $error("rd_retry_ctl: AW must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rd_retry_ctl: DW must be at least 1");
   end
   if (MAX_W < 1 || MAX_W > 6) begin : g_bad_maxw
      $error("rd_retry_ctl: MAX_W must lie in 1..6");
   end

   logic             fin, fin_poison, fin_ce;
   logic [AW-1:0]    fin_addr;
   logic [TRY_W-1:0] fin_tries;

   rd_retry_fsm #(.AW(AW), .MAX_W(MAX_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_retry_en (cfg_retry_en),
      .cfg_max_retry(cfg_max_retry),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .cmd_valid    (cmd_valid),
      .cmd_addr     (cmd_addr),
      .rsp_valid    (rsp_valid),
      .rsp_ecc      (rsp_ecc),
      .fin          (fin),
      .fin_poison   (fin_poison),
      .fin_ce       (fin_ce),
      .fin_addr     (fin_addr),
      .fin_tries    (fin_tries)
   );

   rd_retry_out #(.AW(AW), .DW(DW), .TRY_W(TRY_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .fin       (fin),
      .fin_poison(fin_poison),
      .fin_ce    (fin_ce),
      .fin_addr  (fin_addr),
      .fin_tries (fin_tries),
      .rsp_data  (rsp_data),
      .fwd_valid (fwd_valid),
      .fwd_data  (fwd_data),
      .fwd_poison(fwd_poison),
      .log_ce    (log_ce),
      .log_de    (log_de),
      .log_addr  (log_addr),
      .log_tries (log_tries)
   );

   // R11: the block is ready again right after a forward
   a_r11_ready_after_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |=> req_ready);
   // R2: a forward happens only while the block is busy
   a_r2_fwd_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> !req_ready);
endmodule

// File: tb/rd_retry_ctl_tb.sv
`timescale 1ns/1ps
module rd_retry_ctl_tb;
   localparam int AW  = 32;
   localparam int DW  = 64;
   localparam int MW  = 3;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_retry_en = 1'b0;
   logic [MW-1:0] cfg_max_retry = '0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          cmd_valid;
   logic [AW-1:0] cmd_addr;
   logic          rsp_valid = 1'b0;
   logic [DW-1:0] rsp_data = '0;
   logic [1:0]    rsp_ecc = '0;
   logic          fwd_valid, fwd_poison, log_ce, log_de;
   logic [DW-1:0] fwd_data;
   logic [AW-1:0] log_addr;
   logic [MW:0]   log_tries;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   rd_retry_ctl #(.AW(AW), .DW(DW), .MAX_W(MW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_retry_en(cfg_retry_en),
      .cfg_max_retry(cfg_max_retry), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .cmd_valid(cmd_valid),
      .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_ecc(rsp_ecc), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
      .fwd_poison(fwd_poison), .log_ce(log_ce), .log_de(log_de),
      .log_addr(log_addr), .log_tries(log_tries)
   );

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // One read: sts holds the 2-bit ECC status of attempt i at [2i+:2].
   task automatic run_txn(input logic [AW-1:0] a, input bit en, input int mx,
                          input bit flip, input logic [15:0] sts,
                          input string fin_tag);
      int lim, k;
      int cmd_c[9];
      int rsp_c[9];
      int done_c;
      bit ue_fin;
      logic [DW-1:0] base;
      base = {a, ~a};
      lim = en ? mx : 0;
      k = 0;
      while (k < lim && sts[2*k+1]) k++;
      ue_fin = sts[2*k+1];
      cmd_c[0] = 0;
      for (int i = 0; i <= k; i++) begin
         rsp_c[i] = cmd_c[i] + LAT;
         if (i < 8) cmd_c[i+1] = rsp_c[i] + 1;
      end
      done_c = rsp_c[k] + 1;
      for (int c = 0; c <= done_c + 1; c++) begin
         bit exp_cmd;
         int ci;
         @(negedge clk);
         req_valid = (c == 0);
         req_addr  = a;
         if (c == 0) begin
            cfg_retry_en  = en;
            cfg_max_retry = MW'(mx);
         end else if (flip) begin
            cfg_retry_en  = ~en;
            cfg_max_retry = ~MW'(mx);
         end
         rsp_valid = 1'b0;
         for (int i = 0; i <= k; i++)
            if (c == rsp_c[i]) begin
               rsp_valid = 1'b1;
               rsp_ecc   = sts[2*i+:2];
               rsp_data  = base ^ DW'(i);
            end
         #1;
         exp_cmd = 1'b0;
         ci = -1;
         for (int i = 0; i <= k; i++) if (c == cmd_c[i]) begin exp_cmd = 1'b1; ci = i; end
         chk(ci > 0 ? "R3" : "R2", "cmd_valid", 64'(cmd_valid), 64'(exp_cmd));
         if (exp_cmd) chk(ci > 0 ? "R3" : "R2", "cmd_addr", 64'(cmd_addr), 64'(a));
         chk(c == 0 ? "R2" : "R11", "req_ready", 64'(req_ready),
             64'((c == 0) || (c == done_c + 1)));
         chk("R4", "fwd_valid", 64'(fwd_valid), 64'(c == done_c));
         if (c == done_c) begin
            chk("R4", "fwd_data", fwd_data, base ^ DW'(k));
            chk(fin_tag, "fwd_poison", 64'(fwd_poison), 64'(ue_fin));
            chk(fin_tag, "log_de", 64'(log_de), 64'(ue_fin));
            chk(fin_tag, "log_ce", 64'(log_ce),
                64'(!ue_fin && (k != 0 || sts[1:0] == 2'b01)));
            if (log_ce || log_de) begin
               chk(fin_tag, "log_tries", 64'(log_tries), 64'(k + 1));
               chk(fin_tag, "log_addr", 64'(log_addr), 64'(a));
            end
         end else begin
            chk("R4", "log_ce idle", 64'(log_ce), 64'(0));
            chk("R4", "log_de idle", 64'(log_de), 64'(0));
         end
      end
      req_valid = 1'b0;
      rsp_valid = 1'b0;
   endtask

   initial begin
      #800000;
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "req_ready", 64'(req_ready), 64'(1));
      chk("R1", "cmd_valid", 64'(cmd_valid), 64'(0));
      chk("R1", "fwd_valid", 64'(fwd_valid), 64'(0));
      chk("R1", "logs", 64'({log_ce, log_de}), 64'(0));

      // status codes: 00 clean, 01 correctable, 10/11 uncorrectable
      run_txn(32'h1000_0040, 1'b1, 3, 1'b0, 16'h0000, "R4");
      run_txn(32'h1000_0080, 1'b1, 3, 1'b0, 16'h0001, "R5");
      run_txn(32'h2000_0100, 1'b1, 3, 1'b0, 16'h0002, "R6");
      run_txn(32'h2000_0140, 1'b1, 3, 1'b0, 16'h001E, "R6");
      run_txn(32'h2000_0180, 1'b1, 1, 1'b0, 16'h0002, "R6");
      run_txn(32'h3000_0200, 1'b1, 3, 1'b0, 16'h00AA, "R7");
      run_txn(32'h3000_0240, 1'b1, 7, 1'b0, 16'hFFFF, "R7");
      run_txn(32'h4000_0300, 1'b0, 5, 1'b0, 16'h0002, "R8");
      run_txn(32'h4000_0340, 1'b1, 0, 1'b0, 16'h0003, "R8");
      run_txn(32'h5000_0400, 1'b1, 2, 1'b1, 16'h002A, "R9");
      run_txn(32'h5000_0440, 1'b0, 2, 1'b1, 16'h0002, "R9");

      // R10: stray responses while idle
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         rsp_valid = (c < 2);
         rsp_ecc   = 2'b10;
         rsp_data  = 64'hDEAD;
         #1;
         chk("R10", "fwd_valid", 64'(fwd_valid), 64'(0));
         chk("R10", "cmd_valid", 64'(cmd_valid), 64'(0));
         chk("R10", "logs", 64'({log_ce, log_de}), 64'(0));
         chk("R10", "req_ready", 64'(req_ready), 64'(1));
      end
      rsp_valid = 1'b0;
      run_txn(32'h6000_0500, 1'b1, 2, 1'b0, 16'h0001, "R5");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule